// File: doc/BRIEF.md
# Real-Time Clock Wake-Up Interrupt Controller

This block gathers the event strobes of a real-time clock and merges them onto one active-low wake-up line for a sleeping host. There are four sources: an alarm match, a once-per-second tick, the expiry of a periodic countdown timer and a time-update strobe that marks each minute rollover. The countdown timer is built into the block. The other three strobes arrive as single-cycle pulses from the timekeeping core.

Each source has a sticky flag and an enable. A flag is set by its event whether or not the source is enabled. The wake-up line falls as soon as any flag is set while its enable is set. The host clears flags by writing ones to them. The line is driven only by flags and enables, so it still asserts when no host bus access takes place, as happens while the device runs from backup power.

Top module: `rtcirq_ctrl`

## Requirements
- R1: After reset all flags are 0, all enables are 0, the timer reload value and count are 0, and `irq_n_o` is high.
- R2: A one-cycle pulse on a source input sets that source's flag on the same clock edge, whatever its enable. Flag bit positions: bit 0 is alarm, bit 1 is second tick, bit 2 is countdown timer, bit 3 is minute rollover.
- R3: `irq_n_o` is low in the cycle after any flag is set while its enable is set. It returns high in the cycle after no enabled flag remains.
- R4: A write to address 1 clears every flag whose data bit is 1 and leaves every flag whose data bit is 0.
- R5: When a source event and a host clear of the same flag occur in the same cycle, the flag stays set.
- R6: A set flag whose enable is 0 does not pull `irq_n_o` low. Setting that enable later makes `irq_n_o` go low.
- R7: A write to address 2 loads the low 12 data bits as the reload value and as the current count. On each second tick the count falls by one. On the tick where the count is 1, the timer flag is set and the count reloads, so the flag repeats every reload-value ticks.
- R8: While the reload value is 0 the timer is stopped: the count stays 0 and the timer flag is never set.
- R9: A write to address 0 sets the enables from data bits 3:0, using the same bit positions as the flags. A write to address 3 changes no flag, no enable and no timer state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| alarm_hit_i | input | 1 | Alarm match pulse |
| sec_tick_i | input | 1 | One-second tick pulse; also clocks the countdown timer |
| min_roll_i | input | 1 | Minute rollover (time-update) pulse |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Register address: 0 enables, 1 flag clear, 2 timer reload |
| wr_data_i | input | 16 | Register write data |
| irq_n_o | output | 1 | Active-low wake-up interrupt |
| flags_o | output | 4 | Sticky source flags |
| tmr_count_o | output | 12 | Current countdown value |

## Verification
The bench uses the default parameters: a 16-bit data word, a 12-bit timer and a registered interrupt output. With a registered output, the one-cycle lag of the wake-up line behind the flags can be checked exactly. Small reload values of 1 and 3 bring the count-to-one reload edge within a few ticks. An all-ones write checks that the reload is cut to 12 bits. The 4-bit source vector lets every enable and clear mix be tried, including an event and its clear in the same cycle.

// File: rtl/rtcirq_pkg.sv
package rtcirq_pkg;
   localparam int NUM_SRC   = 4;
   localparam int SRC_ALARM = 0;
   localparam int SRC_SEC   = 1;
   localparam int SRC_TMR   = 2;
   localparam int SRC_MIN   = 3;
   localparam int REG_EN    = 0;
   localparam int REG_CLR   = 1;
   localparam int REG_TMR   = 2;
endpackage

// File: rtl/rtcirq_timer.sv
module rtcirq_timer #(
   parameter int TMR_W = 12
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick_i,
   input  logic             load_i,
   input  logic [TMR_W-1:0] load_val_i,
   output logic [TMR_W-1:0] cnt_o,
   output logic             evt_o
);
   localparam logic [TMR_W-1:0] ONE = TMR_W'(1);

   logic [TMR_W-1:0] reload_q;
   logic [TMR_W-1:0] cnt_q;
   logic             running;
   logic             expire;

   assign running = (reload_q != '0);
   assign expire  = tick_i && !load_i && running && (cnt_q <= ONE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         reload_q <= '0;
         cnt_q    <= '0;
      end else if (load_i) begin
         reload_q <= load_val_i;
         cnt_q    <= load_val_i;
      end else if (tick_i && running) begin
         cnt_q <= expire ? reload_q : cnt_q - ONE;
      end
   end

   assign cnt_o = cnt_q;
   assign evt_o = expire;

   // R7: the count never exceeds the reload value
   p_cnt_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= reload_q);
   // R7: a tick above one decrements by exactly one
   p_cnt_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (tick_i && !load_i && cnt_q > ONE) |=> (cnt_q == $past(cnt_q) - ONE));
   // R8: a zero reload keeps the count at zero
   p_stopped_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (reload_q == '0 && !load_i) |=> (cnt_q == '0));
endmodule

// File: rtl/rtcirq_flag.sv
module rtcirq_flag (
   input  logic clk,
   input  logic rst_n,
   input  logic evt_i,
   input  logic clr_i,
   output logic flag_o
);
   logic flag_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flag_q <= 1'b0;
      else        flag_q <= evt_i || (flag_q && !clr_i);
   end

   assign flag_o = flag_q;

   // R2 and R5: an event always leaves the flag set
   p_evt_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
      evt_i |=> flag_o);
   // R4: a clear with no event empties the flag
   p_clr_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_i && !evt_i) |=> !flag_o);
endmodule

// File: rtl/rtcirq_ctrl.sv
module rtcirq_ctrl
   import rtcirq_pkg::*;
#(
   parameter int DATA_W  = 16,
   parameter int ADDR_W  = 2,
   parameter int TMR_W   = 12,
   parameter bit IRQ_REG = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              alarm_hit_i,
   input  logic              sec_tick_i,
   input  logic              min_roll_i,
   input  logic              wr_en_i,
   input  logic [ADDR_W-1:0] wr_addr_i,
   input  logic [DATA_W-1:0] wr_data_i,
   output logic              irq_n_o,
   output logic [NUM_SRC-1:0] flags_o,
   output logic [TMR_W-1:0]  tmr_count_o
);
   if (DATA_W < TMR_W)   begin : g_chk_tmr  $error("DATA_W must hold the timer reload"); end
   if (DATA_W < NUM_SRC) begin : g_chk_src  $error("DATA_W must hold one bit per source"); end
   if (ADDR_W < 2)       begin : g_chk_addr $error("ADDR_W must reach three registers"); end

   localparam logic [ADDR_W-1:0] A_EN  = ADDR_W'(REG_EN);
   localparam logic [ADDR_W-1:0] A_CLR = ADDR_W'(REG_CLR);
   localparam logic [ADDR_W-1:0] A_TMR = ADDR_W'(REG_TMR);

   logic               wr_en_sel, wr_clr_sel, wr_tmr_sel;
   logic [NUM_SRC-1:0] en_q;
   logic [NUM_SRC-1:0] evt;
   logic [NUM_SRC-1:0] clr;
   logic [NUM_SRC-1:0] flag;
   logic               tmr_evt;
   logic               pend;
   logic               unused_hi;

   assign wr_en_sel  = wr_en_i && (wr_addr_i == A_EN);
   assign wr_clr_sel = wr_en_i && (wr_addr_i == A_CLR);
   assign wr_tmr_sel = wr_en_i && (wr_addr_i == A_TMR);
   assign unused_hi  = ^wr_data_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         en_q <= '0;
      else if (wr_en_sel) en_q <= wr_data_i[NUM_SRC-1:0];
   end

   rtcirq_timer #(.TMR_W(TMR_W)) u_timer (
      .clk        (clk),
      .rst_n      (rst_n),
      .tick_i     (sec_tick_i),
      .load_i     (wr_tmr_sel),
      .load_val_i (wr_data_i[TMR_W-1:0]),
      .cnt_o      (tmr_count_o),
      .evt_o      (tmr_evt)
   );

   always_comb begin
      evt            = '0;
      evt[SRC_ALARM] = alarm_hit_i;
      evt[SRC_SEC]   = sec_tick_i;
      evt[SRC_TMR]   = tmr_evt;
      evt[SRC_MIN]   = min_roll_i;
   end

   assign clr = wr_clr_sel ? wr_data_i[NUM_SRC-1:0] : '0;

   for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
      rtcirq_flag u_flag (
         .clk    (clk),
         .rst_n  (rst_n),
         .evt_i  (evt[i]),
         .clr_i  (clr[i]),
         .flag_o (flag[i])
      );
   end

   assign flags_o = flag;
   assign pend    = |(flag & en_q);

   if (IRQ_REG) begin : g_irq_reg
      logic irq_n_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) irq_n_q <= 1'b1;
         else        irq_n_q <= !pend;
      end
      assign irq_n_o = irq_n_q;

      // R3: an enabled pending flag drives the line low next cycle
      p_irq_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
         pend |=> !irq_n_o);
      // R6: with nothing enabled and pending the line is high next cycle
      p_irq_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
         !pend |=> irq_n_o);
   end else begin : g_irq_comb
      assign irq_n_o = !pend;
   end
endmodule

// File: tb/rtcirq_ctrl_tb.sv
module rtcirq_ctrl_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        alarm_hit_i = 1'b0, sec_tick_i = 1'b0, min_roll_i = 1'b0;
   logic        wr_en_i = 1'b0;
   logic [1:0]  wr_addr_i = '0;
   logic [15:0] wr_data_i = '0;
   logic        irq_n_o;
   logic [3:0]  flags_o;
   logic [11:0] tmr_count_o;

   int n_chk = 0, n_bad = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   rtcirq_ctrl u_dut (
      .clk(clk), .rst_n(rst_n), .alarm_hit_i(alarm_hit_i), .sec_tick_i(sec_tick_i),
      .min_roll_i(min_roll_i), .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i),
      .wr_data_i(wr_data_i), .irq_n_o(irq_n_o), .flags_o(flags_o),
      .tmr_count_o(tmr_count_o)
   );

   // {alarm, sec, min, wr, addr[1:0], data[15:0], exp_flags[3:0], exp_irq_n}
   localparam int NV = 14;
   localparam logic [26:0] VEC [NV] = '{
      {3'b100, 1'b0, 2'd0, 16'h0000, 4'b0001, 1'b1}, // R2 R6 alarm, disabled
      {3'b000, 1'b1, 2'd0, 16'h0001, 4'b0001, 1'b0}, // R9 R3 enable alarm
      {3'b010, 1'b0, 2'd0, 16'h0000, 4'b0011, 1'b0}, // R2 second flag
      {3'b000, 1'b1, 2'd1, 16'h0001, 4'b0010, 1'b1}, // R4 clear alarm only
      {3'b000, 1'b1, 2'd0, 16'h000A, 4'b0010, 1'b0}, // R6 enable later
      {3'b000, 1'b1, 2'd1, 16'h0002, 4'b0000, 1'b1}, // R4 R3 release
      {3'b001, 1'b0, 2'd0, 16'h0000, 4'b1000, 1'b0}, // R2 minute flag
      {3'b001, 1'b1, 2'd1, 16'h0008, 4'b1000, 1'b0}, // R5 event beats clear
      {3'b000, 1'b1, 2'd3, 16'h00FF, 4'b1000, 1'b0}, // R9 address 3 ignored
      {3'b000, 1'b1, 2'd1, 16'h0008, 4'b0000, 1'b1}, // R4
      {3'b111, 1'b1, 2'd0, 16'h0000, 4'b1011, 1'b1}, // R6 all disabled
      {3'b000, 1'b1, 2'd0, 16'h0004, 4'b1011, 1'b1}, // R6 timer enable only
      {3'b000, 1'b1, 2'd0, 16'h000F, 4'b1011, 1'b0}, // R9 R3 enable all
      {3'b000, 1'b1, 2'd1, 16'h000F, 4'b0000, 1'b1}  // R4 clear all
   };

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   // drive at a falling edge, hold across one rising edge, return at the next falling edge
   task automatic drive(input logic a, input logic s, input logic m, input logic w,
                        input logic [1:0] ad, input logic [15:0] d);
      alarm_hit_i = a; sec_tick_i = s; min_roll_i = m;
      wr_en_i = w; wr_addr_i = ad; wr_data_i = d;
      @(negedge clk);
      alarm_hit_i = 0; sec_tick_i = 0; min_roll_i = 0; wr_en_i = 0;
      wr_addr_i = '0; wr_data_i = '0;
   endtask

   task automatic tick();
      drive(1'b0, 1'b1, 1'b0, 1'b0, 2'd0, 16'h0);
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      chk("R1 flags", 32'(flags_o), 32'h0);
      chk("R1 irq_n", 32'(irq_n_o), 32'h1);
      chk("R1 count", 32'(tmr_count_o), 32'h0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 irq_n after release", 32'(irq_n_o), 32'h1);

      for (int i = 0; i < NV; i++) begin
         logic [26:0] v;
         v = VEC[i];
         drive(v[26], v[25], v[24], v[23], v[22:21], v[20:5]);
         chk($sformatf("R2/R4/R5 flags vec %0d", i), 32'(flags_o), 32'(v[4:1]));
         @(negedge clk);
         chk($sformatf("R3/R6 irq_n vec %0d", i), 32'(irq_n_o), 32'(v[0]));
      end

      // R3: line goes low exactly one cycle after the flag
      drive(1'b1, 1'b0, 1'b0, 1'b0, 2'd0, 16'h0);
      chk("R3 flag set", 32'(flags_o[0]), 32'h1);
      chk("R3 irq_n lags one cycle", 32'(irq_n_o), 32'h1);
      @(negedge clk);
      chk("R3 irq_n low", 32'(irq_n_o), 32'h0);
      drive(1'b0, 1'b0, 1'b0, 1'b1, 2'd1, 16'h000F);
      @(negedge clk);

      // R7 timer with reload 3
      drive(1'b0, 1'b0, 1'b0, 1'b1, 2'd2, 16'h0003);
      chk("R7 load count", 32'(tmr_count_o), 32'd3);
      tick();
      chk("R7 count after 1", 32'(tmr_count_o), 32'd2);
      tick();
      chk("R7 count after 2", 32'(tmr_count_o), 32'd1);
      chk("R7 no flag yet", 32'(flags_o[2]), 32'h0);
      tick();
      chk("R7 flag on expiry", 32'(flags_o[2]), 32'h1);
      chk("R7 reload", 32'(tmr_count_o), 32'd3);
      @(negedge clk);
      chk("R7 irq_n timer", 32'(irq_n_o), 32'h0);
      drive(1'b0, 1'b0, 1'b0, 1'b1, 2'd1, 16'h0004);
      tick(); tick();
      chk("R7 no early repeat", 32'(flags_o[2]), 32'h0);
      tick();
      chk("R7 periodic repeat", 32'(flags_o[2]), 32'h1);

      // R7 reload 1 fires on every tick
      drive(1'b0, 1'b0, 1'b0, 1'b1, 2'd2, 16'h0001);
      drive(1'b0, 1'b0, 1'b0, 1'b1, 2'd1, 16'h0004);
      tick();
      chk("R7 reload 1 first", 32'(flags_o[2]), 32'h1);
      drive(1'b0, 1'b0, 1'b0, 1'b1, 2'd1, 16'h0004);
      tick();
      chk("R7 reload 1 second", 32'(flags_o[2]), 32'h1);
      chk("R7 reload 1 count", 32'(tmr_count_o), 32'd1);

      // R7 reload width is 12 bits
      drive(1'b0, 1'b0, 1'b0, 1'b1, 2'd2, 16'hFFFF);
      chk("R7 reload truncated", 32'(tmr_count_o), 32'h0FFF);

      // R8 reload 0 stops the timer
      drive(1'b0, 1'b0, 1'b0, 1'b1, 2'd2, 16'h0000);
      drive(1'b0, 1'b0, 1'b0, 1'b1, 2'd1, 16'h000F);
      for (int k = 0; k < 5; k++) tick();
      chk("R8 count held", 32'(tmr_count_o), 32'h0);
      chk("R8 no timer flag", 32'(flags_o[2]), 32'h0);

      // R9 address 3 leaves the timer alone
      drive(1'b0, 1'b0, 1'b0, 1'b1, 2'd3, 16'h0005);
      chk("R9 addr3 timer", 32'(tmr_count_o), 32'h0);

      finish_run();
   end
endmodule